// File: doc/BRIEF.md
# Multi-Page Access Checker Sequencer

This block vets a logical memory access of any byte length before the data is moved. When a request arrives, it takes the start address, length and direction, and works out how many 4 KB pages the access covers. It then walks those pages in ascending order. Each page goes through a write-protection test for low addresses and then through one translation on a request/acknowledge front-end port. The physical page base that comes back is checked against the size of valid memory. Page bases that pass are gathered into a small output buffer. The low 12 bits of the start address are kept as the byte offset into the first page.

The walk stops at the first fault of any kind. A one-cycle done pulse then reports the outcome, the index of the page that failed, and a fault kind with an exception code. The protection test has two windows: logical addresses below 512, and 4096 up to 4607. It applies only to writes with the protection-enable input set. With translation off it always applies. With translation on it applies only when the selected space is not marked private. All control inputs are sampled with the start request.

Top module: `span_access_checker`

## Requirements
- R1: After reset, `done`, `busy` and `xlReq` are all low.
- R2: The page count is `((startAddr & 0xFFF) + accLen - 1) >> 12` plus one. On success, `pageCount` equals that value and `faultKind` is 0.
- R3: A request with `accLen` of 0, or one whose page count exceeds `MAX_PAGES`, finishes with `faultKind` 1 (length error) and `failIdx` 0. It issues no translation request.
- R4: Protection is active when `isWrite` and `protEnable` are both set, and either `xlateOn` is clear or `privateSpace` is clear. For page i the step address is `startAddr + i*4096`. When protection is active and that step address is below 512, or lies in 4096..4607, the request finishes with `faultKind` 2, `excCode` 0 and `failIdx` i. No translation is issued for that page.
- R5: Translations are issued in ascending page order. `xlVaddr` is the step address with its low 12 bits cleared. `xlReq` stays high until a cycle in which `xlAck` is high.
- R6: An acknowledged translation with `xlFault` set finishes with `faultKind` 3, `excCode` equal to `xlCode`, and `failIdx` set to that page. No further pages are requested.
- R7: A translated page is invalid when its base (`xlPaddr` with the low 12 bits cleared) is at or above `memSize`. An invalid page finishes with `faultKind` 4 and `failIdx` set to that page, and the walk stops.
- R8: On success, buffer entry i (bits `i*ADDR_W +: ADDR_W` of `pageBuf`) holds the base of page i. `pageOffset` holds `startAddr[11:0]`.
- R9: `done` is high for exactly one cycle per accepted request, and `busy` is low while `done` is high.
- R10: Reads are never protected. A write with `xlateOn` and `privateSpace` set, or with `protEnable` clear, passes through the protection windows untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| startReq | input | 1 | Start pulse; ignored while busy |
| startAddr | input | ADDR_W | Logical start address |
| accLen | input | LEN_W | Access length in bytes |
| isWrite | input | 1 | Access is a write |
| protEnable | input | 1 | Low-address protection enable |
| xlateOn | input | 1 | Address translation on |
| privateSpace | input | 1 | Selected space is marked private |
| memSize | input | ADDR_W | Size of valid memory in bytes |
| xlReq | output | 1 | Translation request |
| xlVaddr | output | ADDR_W | Page-aligned logical address to translate |
| xlAck | input | 1 | Translation answer valid |
| xlFault | input | 1 | Translation failed |
| xlCode | input | 8 | Exception code of a failed translation |
| xlPaddr | input | ADDR_W | Translated page address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| faultKind | output | 3 | 0 ok, 1 length, 2 protection, 3 translation, 4 addressing |
| excCode | output | 8 | Exception code (0 except for translation faults) |
| failIdx | output | IDX_W | Index of the failing page |
| pageCount | output | SUM_W | Pages covered by the request |
| pageOffset | output | PAGE_BITS | Byte offset into the first page |
| pageBuf | output | MAX_PAGES*ADDR_W | Translated page bases |

## Verification
The assertions assume the translation responder answers only while `xlReq` is high. They also assume it answers within a bounded number of cycles. The bench responder drives `xlAck` only after it has seen `xlReq` high, after a chosen latency of zero to two cycles. It never starts a request while `busy` is high. Stimulus addresses keep the step addresses below the top of the address range, so the protection windows are reached only through the start address.

// File: rtl/span_chk_pkg.sv
package span_chk_pkg;
  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_LEN   = 3'd1,
    FK_PROT  = 3'd2,
    FK_XLATE = 3'd3,
    FK_ADDR  = 3'd4
  } faultKind_t;

  typedef struct packed {
    logic       load;
    logic       store;
    logic       finish;
    faultKind_t kind;
  } ctrlStrobe_t;

  typedef struct packed {
    logic lenBad;
    logic protHit;
    logic lastPage;
    logic addrBad;
  } dpFlags_t;
endpackage

// File: rtl/span_chk_dp.sv
module span_chk_dp
  import span_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_PAGES = 4,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(MAX_PAGES + 1),
  localparam int SUM_W    = ((LEN_W > PAGE_BITS) ? LEN_W : PAGE_BITS) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobe_t                 strb,
  output dpFlags_t                    flags,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [LEN_W-1:0]            accLen,
  input  logic                        isWrite,
  input  logic                        protEnable,
  input  logic                        xlateOn,
  input  logic                        privateSpace,
  input  logic [ADDR_W-1:0]           memSize,
  input  logic [7:0]                  xlCode,
  input  logic [ADDR_W-1:0]           xlPaddr,
  output logic [ADDR_W-1:0]           xlVaddr,
  output logic [2:0]                  faultKind,
  output logic [7:0]                  excCode,
  output logic [IDX_W-1:0]            failIdx,
  output logic [SUM_W-1:0]            pageCount,
  output logic [PAGE_BITS-1:0]        pageOffset,
  output logic [MAX_PAGES*ADDR_W-1:0] pageBuf
);
  localparam logic [ADDR_W-1:0] PAGE_SIZE = ADDR_W'(1) << PAGE_BITS;
  localparam logic [ADDR_W-1:0] WIN_LEN   = ADDR_W'(512);
  localparam logic [ADDR_W-1:0] OFF_MASK  = PAGE_SIZE - ADDR_W'(1);

  logic [ADDR_W-1:0] curAddr;
  logic [SUM_W-1:0]  cntReg;
  logic [IDX_W-1:0]  idx;
  logic              lenZero;
  logic              protActive;
  logic [ADDR_W-1:0] bufMem [MAX_PAGES];
  logic [SUM_W-1:0]  sumNext;
  logic [ADDR_W-1:0] paddrBase;
  logic              inWindow;

  assign sumNext   = SUM_W'(startAddr[PAGE_BITS-1:0]) + SUM_W'(accLen) - SUM_W'(1);
  assign paddrBase = xlPaddr & ~OFF_MASK;
  assign inWindow  = (curAddr < WIN_LEN) ||
                     ((curAddr >= PAGE_SIZE) && (curAddr < PAGE_SIZE + WIN_LEN));

  assign flags.lenBad   = lenZero || (cntReg > SUM_W'(MAX_PAGES));
  assign flags.protHit  = protActive && inWindow;
  assign flags.lastPage = (SUM_W'(idx) + SUM_W'(1)) == cntReg;
  assign flags.addrBad  = paddrBase >= memSize;

  assign xlVaddr   = curAddr & ~OFF_MASK;
  assign pageCount = cntReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr    <= '0;
      cntReg     <= '0;
      idx        <= '0;
      lenZero    <= 1'b0;
      protActive <= 1'b0;
      pageOffset <= '0;
      faultKind  <= '0;
      excCode    <= '0;
      failIdx    <= '0;
    end else begin
      if (strb.load) begin
        curAddr    <= startAddr;
        cntReg     <= (sumNext >> PAGE_BITS) + SUM_W'(1);
        idx        <= '0;
        lenZero    <= (accLen == '0);
        protActive <= isWrite && protEnable && (!xlateOn || !privateSpace);
        pageOffset <= startAddr[PAGE_BITS-1:0];
      end
      if (strb.store) begin
        idx     <= idx + IDX_W'(1);
        curAddr <= curAddr + PAGE_SIZE;
      end
      if (strb.finish) begin
        faultKind <= strb.kind;
        excCode   <= (strb.kind == FK_XLATE) ? xlCode : 8'd0;
        failIdx   <= idx;
      end
    end
  end

  for (genvar i = 0; i < MAX_PAGES; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bufMem[i] <= '0;
      else if (strb.store && (idx == IDX_W'(i))) bufMem[i] <= paddrBase;
    end
    assign pageBuf[i*ADDR_W +: ADDR_W] = bufMem[i];
  end

  // R3
  store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.store |-> !flags.lenBad);
  // R2
  ok_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.finish && strb.kind == FK_NONE) |-> flags.lastPage);
  // R4
  prot_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.finish && strb.kind == FK_PROT) |-> protActive);
endmodule

// File: rtl/span_chk_ctrl.sv
module span_chk_ctrl
  import span_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        xlAck,
  input  logic        xlFault,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strb,
  output logic        xlReq,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_PAGE, S_REQ} state_t;
  state_t state, stateNext;

  always_comb begin
    strb.load   = 1'b0;
    strb.store  = 1'b0;
    strb.finish = 1'b0;
    strb.kind   = FK_NONE;
    xlReq       = 1'b0;
    stateNext   = state;
    case (state)
      S_IDLE: if (startReq) begin
        strb.load = 1'b1;
        stateNext = S_EVAL;
      end
      S_EVAL: if (flags.lenBad) begin
        strb.finish = 1'b1;
        strb.kind   = FK_LEN;
        stateNext   = S_IDLE;
      end else begin
        stateNext = S_PAGE;
      end
      S_PAGE: if (flags.protHit) begin
        strb.finish = 1'b1;
        strb.kind   = FK_PROT;
        stateNext   = S_IDLE;
      end else begin
        stateNext = S_REQ;
      end
      S_REQ: begin
        xlReq = 1'b1;
        if (xlAck) begin
          if (xlFault) begin
            strb.finish = 1'b1;
            strb.kind   = FK_XLATE;
            stateNext   = S_IDLE;
          end else if (flags.addrBad) begin
            strb.finish = 1'b1;
            strb.kind   = FK_ADDR;
            stateNext   = S_IDLE;
          end else begin
            strb.store = 1'b1;
            if (flags.lastPage) begin
              strb.finish = 1'b1;
              stateNext   = S_IDLE;
            end else begin
              stateNext = S_PAGE;
            end
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.finish;
    end
  end

  assign busy = (state != S_IDLE);

  // R5
  xlreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlReq && !xlAck) |=> xlReq);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4
  noprot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xlReq) |-> !flags.protHit);
endmodule

// File: rtl/span_access_checker.sv
module span_access_checker
  import span_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_PAGES = 4,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(MAX_PAGES + 1),
  localparam int SUM_W    = ((LEN_W > PAGE_BITS) ? LEN_W : PAGE_BITS) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        startReq,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [LEN_W-1:0]            accLen,
  input  logic                        isWrite,
  input  logic                        protEnable,
  input  logic                        xlateOn,
  input  logic                        privateSpace,
  input  logic [ADDR_W-1:0]           memSize,
  output logic                        xlReq,
  output logic [ADDR_W-1:0]           xlVaddr,
  input  logic                        xlAck,
  input  logic                        xlFault,
  input  logic [7:0]                  xlCode,
  input  logic [ADDR_W-1:0]           xlPaddr,
  output logic                        busy,
  output logic                        done,
  output logic [2:0]                  faultKind,
  output logic [7:0]                  excCode,
  output logic [IDX_W-1:0]            failIdx,
  output logic [SUM_W-1:0]            pageCount,
  output logic [PAGE_BITS-1:0]        pageOffset,
  output logic [MAX_PAGES*ADDR_W-1:0] pageBuf
);
  ctrlStrobe_t strb;
  dpFlags_t    flags;

  span_chk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .xlAck(xlAck),
    .xlFault(xlFault), .flags(flags), .strb(strb), .xlReq(xlReq),
    .busy(busy), .done(done)
  );

  span_chk_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_PAGES(MAX_PAGES), .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .flags(flags),
    .startAddr(startAddr), .accLen(accLen), .isWrite(isWrite),
    .protEnable(protEnable), .xlateOn(xlateOn), .privateSpace(privateSpace),
    .memSize(memSize), .xlCode(xlCode), .xlPaddr(xlPaddr), .xlVaddr(xlVaddr),
    .faultKind(faultKind), .excCode(excCode), .failIdx(failIdx),
    .pageCount(pageCount), .pageOffset(pageOffset), .pageBuf(pageBuf)
  );
endmodule

// File: tb/span_access_checker_tb.sv
module span_access_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [31:0] startAddr = '0;
  logic [15:0] accLen = '0;
  logic isWrite = 1'b0, protEnable = 1'b0, xlateOn = 1'b0, privateSpace = 1'b0;
  logic [31:0] memSize = 32'h0100_0000;
  logic xlReq;
  logic [31:0] xlVaddr;
  logic xlAck = 1'b0, xlFault = 1'b0;
  logic [7:0] xlCode = '0;
  logic [31:0] xlPaddr = '0;
  logic busy, done;
  logic [2:0] faultKind;
  logic [7:0] excCode;
  logic [2:0] failIdx;
  logic [16:0] pageCount;
  logic [11:0] pageOffset;
  logic [127:0] pageBuf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ackLat = 0;
  int waitCnt = 0;
  int reqIdx = 0;
  int faultPg = -1;
  int badPg = -1;
  logic expectDone = 1'b0;
  logic prevDone = 1'b0;
  logic [31:0] expVaddrQ [$];

  span_access_checker u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startAddr(startAddr),
    .accLen(accLen), .isWrite(isWrite), .protEnable(protEnable),
    .xlateOn(xlateOn), .privateSpace(privateSpace), .memSize(memSize),
    .xlReq(xlReq), .xlVaddr(xlVaddr), .xlAck(xlAck), .xlFault(xlFault),
    .xlCode(xlCode), .xlPaddr(xlPaddr), .busy(busy), .done(done),
    .faultKind(faultKind), .excCode(excCode), .failIdx(failIdx),
    .pageCount(pageCount), .pageOffset(pageOffset), .pageBuf(pageBuf)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] mapPage(logic [31:0] va);
    return (va ^ 32'h0004_0000) | 32'h0000_0ABC;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // translation responder and per-cycle compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !expectDone) check("R9", 32'(done), 32'd0, "unexpected done");
      if (done && prevDone) check("R9", 32'(done), 32'd0, "done wider than one cycle");
    end
    prevDone = done;
    if (xlReq && !xlAck) begin
      if (waitCnt >= ackLat) begin
        waitCnt = 0;
        if (expVaddrQ.size() == 0) begin
          check("R5", xlVaddr, 32'hFFFF_FFFF, "extra translation request");
        end else begin
          check("R5", xlVaddr, expVaddrQ.pop_front(), "request vaddr");
        end
        xlAck   = 1'b1;
        xlFault = (reqIdx == faultPg);
        xlCode  = 8'h11;
        xlPaddr = (reqIdx == badPg) ? 32'hFF00_0123 : mapPage(xlVaddr);
        reqIdx++;
      end else begin
        waitCnt++;
        xlAck = 1'b0;
      end
    end else begin
      xlAck   = 1'b0;
      xlFault = 1'b0;
    end
  end

  task automatic runCase(string req, logic [31:0] a, logic [15:0] len, logic wr,
                         logic pe, logic xo, logic ps, int lat, int fpg, int bpg);
    int expKind;
    int expIdx;
    int cnt;
    logic protAct;
    logic [31:0] expBuf [4];
    int t;
    expKind = 0;
    expIdx = 0;
    cnt = 0;
    expVaddrQ.delete();
    if (len == 0) begin
      expKind = 1;
    end else begin
      cnt = int'(((a & 32'hFFF) + 32'(len) - 1) >> 12) + 1;
      if (cnt > 4) expKind = 1;
    end
    protAct = wr && pe && (!xo || !ps);
    if (expKind == 0) begin
      for (int i = 0; i < cnt; i++) begin
        logic [31:0] sa;
        sa = a + 32'(i * 4096);
        if (protAct && ((sa < 512) || (sa >= 4096 && sa < 4608))) begin
          expKind = 2; expIdx = i; break;
        end
        expVaddrQ.push_back(sa & 32'hFFFF_F000);
        if (i == fpg) begin expKind = 3; expIdx = i; break; end
        if (i == bpg) begin expKind = 4; expIdx = i; break; end
        expBuf[i] = mapPage(sa & 32'hFFFF_F000) & 32'hFFFF_F000;
      end
    end
    ackLat = lat; faultPg = fpg; badPg = bpg; reqIdx = 0; waitCnt = 0;
    @(negedge clk);
    startAddr = a; accLen = len; isWrite = wr; protEnable = pe;
    xlateOn = xo; privateSpace = ps; startReq = 1'b1;
    expectDone = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    check(req, 32'(done), 32'd1, "done seen");
    check(req, 32'(faultKind), 32'(expKind), "fault kind");
    if (expKind != 0) check(req, 32'(failIdx), 32'(expIdx), "fail index");
    check(req, 32'(excCode), (expKind == 3) ? 32'h11 : 32'd0, "exception code");
    if (expKind == 0) begin
      check("R2", 32'(pageCount), 32'(cnt), "page count");
      check("R8", 32'(pageOffset), a & 32'hFFF, "page offset");
      for (int i = 0; i < cnt; i++)
        check("R8", pageBuf[i*32 +: 32], expBuf[i], "buffer entry");
    end
    check("R5", 32'(expVaddrQ.size()), 32'd0, "missing requests");
    @(negedge clk);
    expectDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", {29'd0, done, busy, xlReq}, 32'd0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {29'd0, done, busy, xlReq}, 32'd0, "idle after reset");
    runCase("R2", 32'h0001_2340, 16'd16, 0, 1, 1, 0, 0, -1, -1);
    runCase("R2", 32'h0002_0FF0, 16'h20, 0, 0, 1, 0, 1, -1, -1);
    runCase("R2", 32'h0003_0000, 16'h4000, 1, 1, 1, 1, 2, -1, -1);
    runCase("R3", 32'h0003_0001, 16'h4000, 0, 0, 0, 0, 0, -1, -1);
    runCase("R3", 32'h0005_0000, 16'd0, 0, 0, 0, 0, 0, -1, -1);
    runCase("R4", 32'h0000_0100, 16'd8, 1, 1, 0, 0, 0, -1, -1);
    runCase("R4", 32'h0000_1050, 16'd8, 1, 1, 1, 0, 0, -1, -1);
    runCase("R4", 32'h0000_01FF, 16'h1000, 1, 1, 0, 1, 0, -1, -1);
    runCase("R4", 32'h0000_0200, 16'h1000, 1, 1, 0, 0, 1, -1, -1);
    runCase("R4", 32'h0000_1200, 16'd4, 1, 1, 0, 0, 0, -1, -1);
    runCase("R10", 32'h0000_0100, 16'd8, 1, 1, 1, 1, 0, -1, -1);
    runCase("R10", 32'h0000_0100, 16'd8, 0, 1, 0, 0, 0, -1, -1);
    runCase("R10", 32'h0000_1100, 16'd8, 1, 0, 0, 0, 1, -1, -1);
    runCase("R6", 32'h0006_0800, 16'h2000, 0, 0, 1, 0, 1, 2, -1);
    runCase("R6", 32'h0006_0000, 16'h10, 0, 0, 1, 0, 0, 0, -1);
    runCase("R7", 32'h0007_0000, 16'h3000, 0, 0, 1, 0, 2, -1, 1);
    runCase("R9", 32'h0008_0FFF, 16'd2, 0, 0, 1, 0, 0, -1, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule